// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and keeps three state bits for each one: enabled, pending and active. A 2-bit priority per line orders the lines. The block presents one request at a time to a processor, together with the exception number of the line that should be served. The processor takes the request with an acknowledge pulse. It ends the handler with a completion pulse that carries the exception number. A line that is already running can be interrupted only by a line of strictly more urgent priority.

Software reaches the state through a small register port. Enables and pending bits each have a set register and a clear register, and writing a 1 to a bit acts on that line. Two registers hold the priority fields and one register reports the active lines. A status output always names the most urgent pending line and flags whether any line is pending. A request on a disabled line is kept as pending, so the line is served once software enables it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all enable, pending, active and priority bits are 0. `irqReq` and `anyPending` are low, and `irqVector` and `pendExc` are 0.
- R2: Writing address 0 sets each enable bit whose data bit is 1, and data bits that are 0 leave their lines unchanged. Reading address 0 or 1 returns the enable bits, with line n at bit n.
- R3: Writing address 1 clears each enable bit whose data bit is 1 and leaves the other enable bits as they were.
- R4: A high `irqIn[n]` sets pending bit n at the next clock edge, whether or not line n is enabled. The pending bit stays set after the input falls. Reading address 2 or 3 returns the pending bits. A pending line that is disabled never raises `irqReq`.
- R5: In the cycle after a pending line is enabled, `irqReq` rises with `irqVector` = n + 16.
- R6: Among lines that are pending, enabled and not active, the lowest priority value wins. When priorities are equal, the lowest line number wins.
- R7: Writing address 2 sets pending bits wherever the data bit is 1. Writing address 3 clears them, but a line whose input is still high is set again by its level.
- R8: `irqAck` while `irqReq` is high moves the presented line from pending to active. Reading address 6 returns the active bits. The pending bit stays clear only if the line's input is low.
- R9: While lines are active, `irqReq` is raised only for a candidate whose priority value is strictly less than the smallest priority value among the active lines.
- R10: `irqDone` with `doneExc` in 16..47 clears active bit `doneExc`-16. Other values of `doneExc` change nothing. A line whose input stayed high is requested again after completion.
- R11: `anyPending` is high when any pending bit is set, including those of disabled lines. `pendExc` gives n + 16 for the most urgent pending line, chosen under the rule of R6 but over all pending lines, and is 0 when no line is pending.
- R12: Address 4 holds the priorities of lines 0..15 and address 5 holds lines 16..31. Line n uses bits [2(n mod 16)+1 : 2(n mod 16)]. Both words read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | Level interrupt requests, one per line |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register write address |
| regWrData | input | 32 | Register write data |
| regRdAddr | input | 3 | Register read address |
| regRdData | output | 32 | Register read data, combinational |
| irqReq | output | 1 | Interrupt request to the processor |
| irqVector | output | 6 | Exception number of the presented line |
| irqAck | input | 1 | Processor takes the presented interrupt |
| irqDone | input | 1 | Handler completion |
| doneExc | input | 6 | Exception number being completed |
| anyPending | output | 1 | At least one line pending |
| pendExc | output | 6 | Exception number of the most urgent pending line |

## Verification
The bench enables a line only after its request has come and gone. A design that gated latching with the enable would never raise a request at that point. It sets two lines of equal priority, so a design that picked the higher line number would present exception 36 instead of 19. It then runs a nested sequence: a line at equal priority must be held back, a more urgent line must preempt, and a design that compared with "less or equal" would raise the request too early. It also checks that a level held through acknowledge reappears after completion, that a completion number outside the valid range leaves the active bits alone, and that the status output reports a disabled line that the request logic must skip.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;
  localparam int IDX_W  = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_SET_EN   = 3'd0,
    A_CLR_EN   = 3'd1,
    A_SET_PEND = 3'd2,
    A_CLR_PEND = 3'd3,
    A_PRIO_LO  = 3'd4,
    A_PRIO_HI  = 3'd5,
    A_ACTIVE   = 3'd6,
    A_UNUSED   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic             wrSetEn;
    logic             wrClrEn;
    logic             wrSetPend;
    logic             wrClrPend;
    logic             wrPrioLo;
    logic             wrPrioHi;
    logic             ack;
    logic             done;
    logic [IDX_W-1:0] doneIdx;
  } strobe_t;
endpackage

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N  = 32,
  parameter int PW = 2,
  parameter int IW = 5
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 valid,
  output logic [IW-1:0]        idx,
  output logic [PW-1:0]        bestPrio
);
  // Walk from the top line down; "<=" lets a lower number take over a tie.
  always_comb begin
    valid    = 1'b0;
    idx      = '0;
    bestPrio = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && (!valid || prio[i] <= bestPrio)) begin
        valid    = 1'b1;
        idx      = IW'(i);
        bestPrio = prio[i];
      end
    end
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ    = 32,
  parameter int EXC_OFFSET = 16,
  parameter int EXC_W      = 6
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              irqAck,
  input  logic              irqReq,
  input  logic              irqDone,
  input  logic [EXC_W-1:0]  doneExc,
  output strobe_t           strobes
);
  localparam logic [EXC_W-1:0] EXC_LO = EXC_W'(EXC_OFFSET);
  localparam logic [EXC_W-1:0] EXC_HI = EXC_W'(EXC_OFFSET + NUM_IRQ - 1);

  logic [EXC_W-1:0] doneRel;
  logic             doneInRange;

  assign doneRel     = doneExc - EXC_LO;
  assign doneInRange = (doneExc >= EXC_LO) && (doneExc <= EXC_HI);

  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      unique case (reg_addr_e'(regAddr))
        A_SET_EN:   strobes.wrSetEn   = 1'b1;
        A_CLR_EN:   strobes.wrClrEn   = 1'b1;
        A_SET_PEND: strobes.wrSetPend = 1'b1;
        A_CLR_PEND: strobes.wrClrPend = 1'b1;
        A_PRIO_LO:  strobes.wrPrioLo  = 1'b1;
        A_PRIO_HI:  strobes.wrPrioHi  = 1'b1;
        default: ;
      endcase
    end
    strobes.ack     = irqAck && irqReq;
    strobes.done    = irqDone && doneInRange;
    strobes.doneIdx = doneRel[IDX_W-1:0];
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ    = 32,
  parameter int PRIO_W     = 2,
  parameter int EXC_OFFSET = 16,
  parameter int EXC_W      = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [REG_W-1:0]   wrData,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [REG_W-1:0]   rdData,
  output logic [NUM_IRQ-1:0] enableQ,
  output logic [NUM_IRQ-1:0] pendQ,
  output logic [NUM_IRQ-1:0] activeQ,
  output logic               irqReq,
  output logic [EXC_W-1:0]   irqVector,
  output logic               anyPending,
  output logic [EXC_W-1:0]   pendExc
);
  localparam int LPW = REG_W / PRIO_W;
  localparam logic [EXC_W-1:0] EXC_BASE = EXC_W'(EXC_OFFSET);

  logic [NUM_IRQ-1:0][PRIO_W-1:0] prioQ;
  logic [NUM_IRQ-1:0] lineMask, ackMask, doneMask;
  logic [REG_W-1:0]   prioLoWord, prioHiWord;

  logic              winValid, runValid, stValid;
  logic [IDX_W-1:0]  winIdx, runIdx, stIdx;
  logic [PRIO_W-1:0] winPrio, runPrio, stPrio;

  assign lineMask = wrData[NUM_IRQ-1:0];
  assign ackMask  = strobes.ack  ? (NUM_IRQ'(1) << winIdx) : '0;
  assign doneMask = strobes.done ? (NUM_IRQ'(1) << strobes.doneIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      pendQ   <= '0;
      activeQ <= '0;
    end else begin
      if (strobes.wrSetEn) enableQ <= enableQ | lineMask;
      else if (strobes.wrClrEn) enableQ <= enableQ & ~lineMask;
      pendQ <= (pendQ & ~(ackMask | (strobes.wrClrPend ? lineMask : '0)))
             | (strobes.wrSetPend ? lineMask : '0)
             | irqIn;
      activeQ <= (activeQ | ackMask) & ~doneMask;
    end
  end

  // One priority field per line, placed in the low or high word by line number.
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
    localparam int SLOT  = g % LPW;
    localparam bit IN_HI = (g >= LPW);
    logic wrHit;
    assign wrHit = IN_HI ? strobes.wrPrioHi : strobes.wrPrioLo;
    always_ff @(posedge clk) begin
      if (!rstN) prioQ[g] <= '0;
      else if (wrHit) prioQ[g] <= wrData[SLOT*PRIO_W +: PRIO_W];
    end
  end

  always_comb begin
    prioLoWord = '0;
    prioHiWord = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (i < LPW) prioLoWord[(i % LPW)*PRIO_W +: PRIO_W] = prioQ[i];
      else         prioHiWord[(i % LPW)*PRIO_W +: PRIO_W] = prioQ[i];
    end
  end

  irqc_arbiter #(.N(NUM_IRQ), .PW(PRIO_W), .IW(IDX_W)) u_serve (
    .req(pendQ & enableQ & ~activeQ), .prio(prioQ),
    .valid(winValid), .idx(winIdx), .bestPrio(winPrio));

  irqc_arbiter #(.N(NUM_IRQ), .PW(PRIO_W), .IW(IDX_W)) u_running (
    .req(activeQ), .prio(prioQ),
    .valid(runValid), .idx(runIdx), .bestPrio(runPrio));

  irqc_arbiter #(.N(NUM_IRQ), .PW(PRIO_W), .IW(IDX_W)) u_status (
    .req(pendQ), .prio(prioQ),
    .valid(stValid), .idx(stIdx), .bestPrio(stPrio));

  assign irqReq     = winValid && (!runValid || (winPrio < runPrio));
  assign irqVector  = irqReq ? ({{(EXC_W-IDX_W){1'b0}}, winIdx} + EXC_BASE) : '0;
  assign anyPending = stValid;
  assign pendExc    = stValid ? ({{(EXC_W-IDX_W){1'b0}}, stIdx} + EXC_BASE) : '0;

  always_comb begin
    unique case (reg_addr_e'(rdAddr))
      A_SET_EN, A_CLR_EN:     rdData = REG_W'(enableQ);
      A_SET_PEND, A_CLR_PEND: rdData = REG_W'(pendQ);
      A_PRIO_LO:              rdData = prioLoWord;
      A_PRIO_HI:              rdData = prioHiWord;
      A_ACTIVE:               rdData = REG_W'(activeQ);
      default:                rdData = '0;
    endcase
  end

  logic unusedSig;
  assign unusedSig = ^{runIdx, stPrio};
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_IRQ    = 32,
  parameter int PRIO_W     = 2,
  parameter int EXC_OFFSET = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWrData,
  input  logic [2:0]         regRdAddr,
  output logic [31:0]        regRdData,
  output logic               irqReq,
  output logic [5:0]         irqVector,
  input  logic               irqAck,
  input  logic               irqDone,
  input  logic [5:0]         doneExc,
  output logic               anyPending,
  output logic [5:0]         pendExc
);
  localparam int EXC_W = 6;

  irqc_pkg::strobe_t strobes;
  logic [NUM_IRQ-1:0] enableQ, pendQ, activeQ;

  irqc_ctrl #(.NUM_IRQ(NUM_IRQ), .EXC_OFFSET(EXC_OFFSET), .EXC_W(EXC_W)) u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .irqAck(irqAck), .irqReq(irqReq),
    .irqDone(irqDone), .doneExc(doneExc), .strobes(strobes));

  irqc_datapath #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .EXC_OFFSET(EXC_OFFSET),
                  .EXC_W(EXC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData), .irqIn(irqIn),
    .rdAddr(regRdAddr), .rdData(regRdData), .enableQ(enableQ), .pendQ(pendQ),
    .activeQ(activeQ), .irqReq(irqReq), .irqVector(irqVector),
    .anyPending(anyPending), .pendExc(pendExc));
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NUM_IRQ = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_IRQ-1:0] irqIn,
  input logic               regWrEn,
  input logic [2:0]         regAddr,
  input logic               irqReq,
  input logic [5:0]         irqVector,
  input logic               irqAck,
  input logic               irqDone,
  input logic [5:0]         doneExc,
  input logic [NUM_IRQ-1:0] enableQ,
  input logic [NUM_IRQ-1:0] pendQ,
  input logic [NUM_IRQ-1:0] activeQ
);
  logic [5:0] vecRel, doneRel;
  assign vecRel  = irqVector - 6'd16;
  assign doneRel = doneExc - 6'd16;

  // R4
  req_line_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (enableQ[vecRel[4:0]] && pendQ[vecRel[4:0]] && !activeQ[vecRel[4:0]]));

  // R8
  ack_activates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq) |=> activeQ[$past(vecRel[4:0])]);

  // R10
  done_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqDone && doneExc >= 6'd16 && doneExc <= 6'd47) |=> !activeQ[$past(doneRel[4:0])]);

  // R3
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == 3'd1) |=> (($past(enableQ) & ~enableQ) == '0));

  // R7
  pend_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == 3'd2) |=> ((pendQ & ~$past(pendQ) & ~$past(irqIn)) == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWrEn(regWrEn), .regAddr(regAddr),
  .irqReq(irqReq), .irqVector(irqVector), .irqAck(irqAck), .irqDone(irqDone),
  .doneExc(doneExc), .enableQ(enableQ), .pendQ(pendQ), .activeQ(activeQ));

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_IN = 3'd2, OP_REQ = 3'd3,
                         OP_ACK = 3'd4, OP_DONE = 3'd5, OP_STAT = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 58;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,   3'd0, 32'h0,        4'd1},  // R1 enables clear
    '{OP_STAT, 3'd0, 32'h0,        4'd1},  // R1 nothing pending
    '{OP_RD,   3'd6, 32'h0,        4'd1},  // R1 nothing active
    '{OP_IN,   3'd0, 32'h20,       4'd4},  // R4 line 5 high while disabled
    '{OP_REQ,  3'd0, 32'h0,        4'd4},  // R4 no request
    '{OP_RD,   3'd2, 32'h20,       4'd4},  // R4 pending latched
    '{OP_STAT, 3'd0, 32'h55,       4'd11}, // R11 exc 21
    '{OP_IN,   3'd0, 32'h0,        4'd4},  // R4 input falls
    '{OP_RD,   3'd2, 32'h20,       4'd4},  // R4 pending kept
    '{OP_WR,   3'd0, 32'h20,       4'd5},  // R5 enable line 5
    '{OP_REQ,  3'd0, 32'h55,       4'd5},  // R5 request exc 21
    '{OP_WR,   3'd0, 32'h100,      4'd2},  // R2
    '{OP_WR,   3'd0, 32'h0,        4'd2},  // R2 zero write
    '{OP_RD,   3'd0, 32'h120,      4'd2},  // R2
    '{OP_WR,   3'd1, 32'h100,      4'd3},  // R3 clear line 8
    '{OP_RD,   3'd0, 32'h20,       4'd3},  // R3
    '{OP_REQ,  3'd0, 32'h55,       4'd3},  // R3 line 5 untouched
    '{OP_WR,   3'd4, 32'h840,      4'd12}, // R12 line3=1 line5=2
    '{OP_WR,   3'd5, 32'h100,      4'd12}, // R12 line20=1
    '{OP_RD,   3'd4, 32'h840,      4'd12}, // R12
    '{OP_RD,   3'd5, 32'h100,      4'd12}, // R12
    '{OP_WR,   3'd0, 32'h100028,   4'd6},  // R6 enable 3,5,20
    '{OP_WR,   3'd2, 32'h100008,   4'd7},  // R7 set pending 3,20
    '{OP_REQ,  3'd0, 32'h53,       4'd6},  // R6 tie goes to line 3
    '{OP_ACK,  3'd0, 32'h0,        4'd8},  // R8
    '{OP_RD,   3'd6, 32'h8,        4'd8},  // R8 line 3 active
    '{OP_RD,   3'd2, 32'h100020,   4'd8},  // R8 pending 3 cleared
    '{OP_REQ,  3'd0, 32'h0,        4'd9},  // R9 equal priority held
    '{OP_WR,   3'd4, 32'h40,       4'd9},  // R9 line5 -> 0
    '{OP_REQ,  3'd0, 32'h55,       4'd9},  // R9 preempt
    '{OP_ACK,  3'd0, 32'h0,        4'd9},  // R9
    '{OP_REQ,  3'd0, 32'h0,        4'd9},  // R9 nested
    '{OP_DONE, 3'd0, 32'd21,       4'd10}, // R10
    '{OP_RD,   3'd6, 32'h8,        4'd10}, // R10
    '{OP_REQ,  3'd0, 32'h0,        4'd9},  // R9
    '{OP_DONE, 3'd0, 32'd19,       4'd10}, // R10
    '{OP_REQ,  3'd0, 32'h64,       4'd10}, // R10 line 20 now
    '{OP_WR,   3'd3, 32'h100000,   4'd7},  // R7 clear pending 20
    '{OP_RD,   3'd2, 32'h0,        4'd7},  // R7
    '{OP_STAT, 3'd0, 32'h0,        4'd11}, // R11
    '{OP_IN,   3'd0, 32'h8,        4'd10}, // R10 line 3 level
    '{OP_REQ,  3'd0, 32'h53,       4'd10}, // R10
    '{OP_ACK,  3'd0, 32'h0,        4'd8},  // R8
    '{OP_RD,   3'd2, 32'h8,        4'd10}, // R10 level re-pends
    '{OP_RD,   3'd6, 32'h8,        4'd8},  // R8
    '{OP_REQ,  3'd0, 32'h0,        4'd9},  // R9 active excluded
    '{OP_DONE, 3'd0, 32'd19,       4'd10}, // R10
    '{OP_REQ,  3'd0, 32'h53,       4'd10}, // R10 requested again
    '{OP_IN,   3'd0, 32'h0,        4'd8},  // R8
    '{OP_ACK,  3'd0, 32'h0,        4'd8},  // R8
    '{OP_RD,   3'd2, 32'h0,        4'd8},  // R8 pending gone
    '{OP_DONE, 3'd0, 32'd19,       4'd10}, // R10
    '{OP_REQ,  3'd0, 32'h0,        4'd10}, // R10
    '{OP_WR,   3'd2, 32'h22,       4'd11}, // R11 pend 1 (disabled) and 5
    '{OP_STAT, 3'd0, 32'h51,       4'd11}, // R11 exc 17
    '{OP_REQ,  3'd0, 32'h55,       4'd11}, // R11 disabled line skipped
    '{OP_WR,   3'd3, 32'h22,       4'd7},  // R7
    '{OP_STAT, 3'd0, 32'h0,        4'd11}  // R11
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [2:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        irqReq;
  logic [5:0]  irqVector;
  logic        irqAck = 1'b0;
  logic        irqDone = 1'b0;
  logic [5:0]  doneExc = '0;
  logic        anyPending;
  logic [5:0]  pendExc;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .irqReq(irqReq), .irqVector(irqVector), .irqAck(irqAck), .irqDone(irqDone),
    .doneExc(doneExc), .anyPending(anyPending), .pendExc(pendExc));

  task automatic compare(input int req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    regWrEn = 1'b0; irqAck = 1'b0; irqDone = 1'b0;
    case (v.op)
      OP_WR:   begin regWrEn = 1'b1; regAddr = v.addr; regWrData = v.data; end
      OP_RD:   regRdAddr = v.addr;
      OP_IN:   irqIn = v.data;
      OP_ACK:  irqAck = 1'b1;
      OP_DONE: begin irqDone = 1'b1; doneExc = v.data[5:0]; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    case (v.op)
      OP_RD:   compare(int'(v.req), regRdData, v.data);
      OP_REQ:  compare(int'(v.req), {25'd0, irqReq, irqVector}, v.data);
      OP_STAT: compare(int'(v.req), {25'd0, anyPending, pendExc}, v.data);
      default: ;
    endcase
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R10 out-of-range completion leaves active bits alone
    step('{OP_WR, 3'd2, 32'h20, 4'd10});
    step('{OP_ACK, 3'd0, 32'h0, 4'd10});
    step('{OP_DONE, 3'd0, 32'd5, 4'd10});
    step('{OP_RD, 3'd6, 32'h20, 4'd10});
    step('{OP_DONE, 3'd0, 32'd48, 4'd10});
    step('{OP_RD, 3'd6, 32'h20, 4'd10});

    // R1 reset from a dirty state
    @(negedge clk);
    regWrEn = 1'b0; irqAck = 1'b0; irqDone = 1'b0; rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    step('{OP_RD, 3'd0, 32'h0, 4'd1});
    step('{OP_RD, 3'd4, 32'h0, 4'd1});
    step('{OP_RD, 3'd6, 32'h0, 4'd1});
    step('{OP_REQ, 3'd0, 32'h0, 4'd1});
    step('{OP_STAT, 3'd0, 32'h0, 4'd1});

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule